// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Row Generator

This block is the front half of a radix-4 Booth multiplier. It takes a multiplicand and a multiplier of the same even width and produces the rows of partial products. Each row is already shifted into place and padded to the full product width. A downstream compressor tree and a final adder add the rows together. The block does no summing itself. It is purely combinational. A parameter chooses whether the operands are two's complement or unsigned.

The multiplier is scanned two bits at a time. Each overlapping bit triple becomes a small set of select strobes (one, two, negate) that drive a row of per-bit decoders. Each row holds the ones'-complement form of |digit|·multiplicand. The "+1" that completes the negation travels into the free low positions of the next row. Each row also carries a short constant tail in place of full sign extension. As a result, a plain modulo-2^(2·WIDTH) sum of all rows gives the product. In unsigned mode, one extra row handles the multiplier's top bit. In signed mode, that last row carries only the negation carry of the row below it. WIDTH must be even and at least 4. Any other value stops elaboration, and narrower operands are expected to use a plain multiplier.

Top module: `booth_pp_gen`

## Requirements
- R1: The output holds WIDTH/2+1 rows, each 2·WIDTH bits wide, with row i at index i.
- R2: With SIGNED_MODE=1, the sum of all rows modulo 2^(2·WIDTH) equals the two's complement product of opA and opB.
- R3: With SIGNED_MODE=0, the sum of all rows modulo 2^(2·WIDTH) equals the unsigned product. The last row uses the digit from the triple (opB[WIDTH-1],0,0).
- R4: Row i uses the triple (y0,y1,y2) = (opB[2i-1],opB[2i],opB[2i+1]), where opB[-1] is 0. The digit is d = y0+y1-2·y2. Bits [2i+WIDTH:2i] of the row are (|d|·opA) xor neg, taken as WIDTH+1 bits, with neg = y2. In signed mode opA is sign-extended into that width. In unsigned mode it is zero-extended.
- R5: For i ≥ 1, row i bit 2i-2 equals opB[2i-1], the negate flag of row i-1. All row i bits below 2i-2, and bit 2i-1, are 0. Row 0 carries no such bit.
- R6: Row 0 bits WIDTH+1 and WIDTH+2 both equal the row sign σ0, and bit WIDTH+3 equals ~σ0. σ0 is neg in unsigned mode and the top bit of the row vector in signed mode.
- R7: For i ≥ 1, row i bit 2i+WIDTH+1 equals ~σi and bit 2i+WIDTH+2 is 1, wherever those positions lie below 2·WIDTH.
- R8: With SIGNED_MODE=1, the last row holds only its negation bit at position WIDTH-2. All its other bits are 0.
- R9: Every row bit above that row's tail is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier, scanned in bit triples |
| ppRows | output | (WIDTH/2+1)×2·WIDTH | Aligned partial product rows, packed, row i at index i |

## Verification
The bound checker tests, on every input change, the structural rules:

- the product sum in the active mode;
- the negate-carry positions and the zeros around them;
- the row 0 and later-row tails;
- the empty padding above each tail.

Only the bench scenarios can show the per-triple digit decoding against an independently computed |d|·opA. The same holds for the unsigned-only extra digit row and for the behaviour at the operand extremes, such as the most negative value squared or all-ones unsigned. Those scenarios run exhaustively at 4 and 6 bits and by random and corner values at 16 bits.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

  // Select strobes handed from the digit encoder to a row of decoders.
  typedef struct packed {
    logic one;   // |digit| == 1
    logic two;   // |digit| == 2
    logic neg;   // digit is negative (or negative zero)
  } boothSel_t;

endpackage

// File: rtl/booth_sel_ctrl.sv
module booth_sel_ctrl
  import booth_pp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int ROWS       = WIDTH / 2 + 1
) (
  input  logic                       [WIDTH-1:0] mult,
  output boothSel_t [ROWS-1:0]                   selRows
);

  // Index 0 is the implicit zero below multiplier bit 0.
  // Indices above WIDTH are zero: in unsigned mode they give the extra
  // non-negative digit, in signed mode that row is masked below.
  logic [WIDTH+2:0] multExt;
  assign multExt = {2'b00, mult, 1'b0};

  for (genvar gi = 0; gi < ROWS; gi++) begin : g_enc
    boothSel_t encSel;

    booth_sel_enc enc_i (
      .yLow (multExt[2*gi]),
      .yMid (multExt[2*gi+1]),
      .yHigh(multExt[2*gi+2]),
      .sel  (encSel)
    );

    if (SIGNED_MODE && (gi == ROWS - 1)) begin : g_mask
      // The signed multiplier is fully covered by the rows below.
      assign selRows[gi] = '0;
    end else begin : g_pass
      assign selRows[gi] = encSel;
    end
  end

endmodule

module booth_sel_enc
  import booth_pp_pkg::*;
(
  input  logic      yLow,
  input  logic      yMid,
  input  logic      yHigh,
  output boothSel_t sel
);

  always_comb begin
    sel.one = yLow ^ yMid;
    sel.two = (yHigh & ~yMid & ~yLow) | (~yHigh & yMid & yLow);
    sel.neg = yHigh;
  end

endmodule

// File: rtl/booth_row_dec.sv
module booth_row_dec
  import booth_pp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b1,
  parameter bit FIRST_ROW   = 1'b0,
  localparam int RW         = WIDTH + 4
) (
  input  logic      [WIDTH-1:0] mcand,
  input  boothSel_t             sel,
  output logic      [RW-1:0]    rowBits
);

  // xExt[j+1] = mcand[j], xExt[0] = implicit zero below bit 0.
  logic [WIDTH:0] xExt;
  logic [WIDTH:0] vec;
  logic           rowSign;

  assign xExt = {mcand, 1'b0};

  for (genvar gj = 0; gj < WIDTH; gj++) begin : g_bit
    assign vec[gj] = ((sel.one & xExt[gj+1]) | (sel.two & xExt[gj])) ^ sel.neg;
  end

  if (SIGNED_MODE) begin : g_top_s
    // Redundant top position decodes the multiplicand MSB once more.
    assign vec[WIDTH] = ((sel.one & mcand[WIDTH-1]) | (sel.two & mcand[WIDTH-1])) ^ sel.neg;
    assign rowSign    = sel.neg ^ (mcand[WIDTH-1] & (sel.one | sel.two));
  end else begin : g_top_u
    // Only a doubled multiplicand reaches the extra position.
    assign vec[WIDTH] = (sel.two & mcand[WIDTH-1]) ^ sel.neg;
    assign rowSign    = sel.neg;
  end

  if (FIRST_ROW) begin : g_tail0
    assign rowBits = {~rowSign, rowSign, rowSign, vec};
  end else begin : g_tailn
    assign rowBits = {1'b0, 1'b1, ~rowSign, vec};
  end

endmodule

// File: rtl/booth_pp_array.sv
module booth_pp_array
  import booth_pp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int ROWS       = WIDTH / 2 + 1,
  localparam int PW         = 2 * WIDTH,
  localparam int RW         = WIDTH + 4,
  localparam int XW         = PW + RW
) (
  input  logic                [WIDTH-1:0] mcand,
  input  boothSel_t [ROWS-1:0]            selRows,
  output logic      [ROWS-1:0][PW-1:0]    rows
);

  for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
    logic [RW-1:0] rowBits;
    logic [XW-1:0] shifted;

    booth_row_dec #(
      .WIDTH      (WIDTH),
      .SIGNED_MODE(SIGNED_MODE),
      .FIRST_ROW  (gi == 0)
    ) dec_i (
      .mcand  (mcand),
      .sel    (selRows[gi]),
      .rowBits(rowBits)
    );

    assign shifted = XW'(rowBits) << (2 * gi);

    if (gi == 0) begin : g_nocarry
      assign rows[gi] = shifted[PW-1:0];
    end else begin : g_carry
      // Completes the negation of the row below, in a free slot.
      logic [PW-1:0] carryIn;
      assign carryIn  = PW'(selRows[gi-1].neg) << (2 * gi - 2);
      assign rows[gi] = shifted[PW-1:0] | carryIn;
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int ROWS       = WIDTH / 2 + 1,
  localparam int PW         = 2 * WIDTH
) (
  input  logic [WIDTH-1:0]         opA,
  input  logic [WIDTH-1:0]         opB,
  output logic [ROWS-1:0][PW-1:0]  ppRows
);

  if ((WIDTH < 4) || (WIDTH % 2 != 0)) begin : g_bad_width
    $error("booth_pp_gen: WIDTH must be even and at least 4");
  end

  boothSel_t [ROWS-1:0] selRows;

  booth_sel_ctrl #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) ctrl_i (
    .mult   (opB),
    .selRows(selRows)
  );

  booth_pp_array #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) dp_i (
    .mcand  (opA),
    .selRows(selRows),
    .rows   (ppRows)
  );

endmodule

// File: rtl/booth_pp_chk.sv
module booth_pp_chk #(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b1,
  localparam int ROWS       = WIDTH / 2 + 1,
  localparam int PW         = 2 * WIDTH
) (
  input logic [WIDTH-1:0]        opA,
  input logic [WIDTH-1:0]        opB,
  input logic [ROWS-1:0][PW-1:0] ppRows
);

  logic [PW-1:0] total;
  logic [PW-1:0] aX;
  logic [PW-1:0] bX;
  logic [PW-1:0] prod;
  logic          sign0;

  always_comb begin
    total = '0;
    for (int i = 0; i < ROWS; i++) total = total + ppRows[i];
    aX    = {{WIDTH{SIGNED_MODE & opA[WIDTH-1]}}, opA};
    bX    = {{WIDTH{SIGNED_MODE & opB[WIDTH-1]}}, opB};
    prod  = aX * bX;
    sign0 = SIGNED_MODE ? (opB[1] ^ (opA[WIDTH-1] & (opB[0] | opB[1]))) : opB[1];

    // R2 R3
    product_sum_chk: assert (total == prod);

    // R6
    row0_tail_chk: assert (ppRows[0][WIDTH+1] == sign0 && ppRows[0][WIDTH+2] == sign0
                           && ppRows[0][WIDTH+3] == ~sign0);

    for (int i = 1; i < ROWS; i++) begin
      for (int j = 0; j < 2 * i; j++) begin
        if (j == 2 * i - 2) begin
          // R5
          neg_carry_chk: assert (ppRows[i][j] == opB[2*i-1]);
        end else begin
          // R5
          low_zero_chk: assert (ppRows[i][j] == 1'b0);
        end
      end
      if (2 * i + WIDTH + 2 < PW) begin
        // R7
        tail_one_chk: assert (ppRows[i][2*i+WIDTH+2] == 1'b1);
      end
      for (int j = 2 * i + WIDTH + 3; j < PW; j++) begin
        // R9
        upper_zero_chk: assert (ppRows[i][j] == 1'b0);
      end
    end

    for (int j = WIDTH + 4; j < PW; j++) begin
      // R9
      row0_upper_zero_chk: assert (ppRows[0][j] == 1'b0);
    end

    if (SIGNED_MODE) begin
      // R8
      last_row_chk: assert (ppRows[ROWS-1] == (PW'(opB[WIDTH-1]) << (WIDTH - 2)));
    end
  end

endmodule

bind booth_pp_gen booth_pp_chk #(
  .WIDTH      (WIDTH),
  .SIGNED_MODE(SIGNED_MODE)
) chk_i (
  .opA   (opA),
  .opB   (opB),
  .ppRows(ppRows)
);

// File: tb/booth_pp_gen_tb_top.sv
`timescale 1ns/1ps
module booth_pp_gen_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0]  a4, b4;
  logic [5:0]  a6, b6;
  logic [15:0] a16, b16;
  logic [2:0][7:0]   r4s, r4u;
  logic [3:0][11:0]  r6s, r6u;
  logic [8:0][31:0]  r16s, r16u;
  logic [7:0]  s4s, s4u;
  logic [11:0] s6s, s6u;
  logic [31:0] s16s, s16u;

  booth_pp_gen #(.WIDTH(16), .SIGNED_MODE(1'b1)) dut_i  (.opA(a16), .opB(b16), .ppRows(r16s));
  booth_pp_gen #(.WIDTH(16), .SIGNED_MODE(1'b0)) d16u_i (.opA(a16), .opB(b16), .ppRows(r16u));
  booth_pp_gen #(.WIDTH(4),  .SIGNED_MODE(1'b1)) d4s_i  (.opA(a4),  .opB(b4),  .ppRows(r4s));
  booth_pp_gen #(.WIDTH(4),  .SIGNED_MODE(1'b0)) d4u_i  (.opA(a4),  .opB(b4),  .ppRows(r4u));
  booth_pp_gen #(.WIDTH(6),  .SIGNED_MODE(1'b1)) d6s_i  (.opA(a6),  .opB(b6),  .ppRows(r6s));
  booth_pp_gen #(.WIDTH(6),  .SIGNED_MODE(1'b0)) d6u_i  (.opA(a6),  .opB(b6),  .ppRows(r6u));

  always_comb begin
    s4s = '0; s4u = '0; s6s = '0; s6u = '0; s16s = '0; s16u = '0;
    for (int i = 0; i < 3; i++) begin s4s += r4s[i]; s4u += r4u[i]; end
    for (int i = 0; i < 4; i++) begin s6s += r6s[i]; s6u += r6u[i]; end
    for (int i = 0; i < 9; i++) begin s16s += r16s[i]; s16u += r16u[i]; end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Field checks on one 6-bit instance (R4..R9).
  task automatic fields6(input bit sgn, input logic [3:0][11:0] rr,
                         input logic [5:0] a, input logic [5:0] b);
    int av;
    int d0, d1, m0, m1;
    logic [6:0] v0, v1;
    logic s0, s1;
    av = sgn ? int'($signed(a)) : int'(a);
    d0 = int'(b[0]) - 2 * int'(b[1]);
    d1 = int'(b[1]) + int'(b[2]) - 2 * int'(b[3]);
    m0 = (d0 < 0) ? -d0 : d0;
    m1 = (d1 < 0) ? -d1 : d1;
    v0 = 7'(m0 * av) ^ {7{b[1]}};
    v1 = 7'(m1 * av) ^ {7{b[3]}};
    chk("R4 row0 vector", 64'(rr[0][6:0]), 64'(v0));
    chk("R4 row1 vector", 64'(rr[1][8:2]), 64'(v1));
    s0 = sgn ? v0[6] : b[1];
    s1 = sgn ? v1[6] : b[3];
    chk("R6 row0 tail", 64'(rr[0][9:7]), 64'({~s0, s0, s0}));
    chk("R7 row1 tail", 64'(rr[1][10:9]), 64'({1'b1, ~s1}));
    for (int i = 1; i < 4; i++) begin
      chk("R5 carry slot", 64'(rr[i] & ((12'd1 << (2 * i)) - 12'd1)),
          64'(12'(b[2*i-1]) << (2 * i - 2)));
    end
    if (sgn) chk("R8 last row", 64'(rr[3]), 64'(12'(b[5]) << 4));
    chk("R9 row0 pad", 64'(rr[0][11:10]), 64'd0);
    chk("R9 row1 pad", 64'(rr[1][11]), 64'd0);
  endtask

  task automatic t_shape();
    chk("R1 rows16", 64'($size(r16s, 1)), 64'd9);
    chk("R1 bits16", 64'($bits(r16s)), 64'(9 * 32));
    chk("R1 rows6", 64'($size(r6u, 1)), 64'd4);
    chk("R1 bits4", 64'($bits(r4s)), 64'(3 * 8));
  endtask

  task automatic t_zero();
    @(posedge clk);
    a4 = '0; b4 = '0; a6 = '0; b6 = '0; a16 = '0; b16 = '0;
    @(negedge clk);
    chk("R2 zero signed", 64'(s16s), 64'd0);
    chk("R3 zero unsigned", 64'(s16u), 64'd0);
    chk("R6 zero tail", 64'(r16s[0][19:17]), 64'(3'b100));
    fields6(1'b1, r6s, a6, b6);
  endtask

  task automatic t_exhaustive();
    for (int idx = 0; idx < 4096; idx++) begin
      longint p;
      @(posedge clk);
      a6 = idx[11:6]; b6 = idx[5:0];
      a4 = idx[7:4];  b4 = idx[3:0];
      @(negedge clk);
      p = longint'($signed(a6)) * longint'($signed(b6));
      chk("R2 w6 signed", 64'(s6s), 64'(p[11:0]));
      p = longint'(a6) * longint'(b6);
      chk("R3 w6 unsigned", 64'(s6u), 64'(p[11:0]));
      if (idx < 256) begin
        p = longint'($signed(a4)) * longint'($signed(b4));
        chk("R2 w4 signed", 64'(s4s), 64'(p[7:0]));
        p = longint'(a4) * longint'(b4);
        chk("R3 w4 unsigned", 64'(s4u), 64'(p[7:0]));
      end
      fields6(1'b1, r6s, a6, b6);
      fields6(1'b0, r6u, a6, b6);
    end
  endtask

  task automatic check16(input string tag);
    longint p;
    p = longint'($signed(a16)) * longint'($signed(b16));
    chk({"R2 w16 ", tag}, 64'(s16s), 64'(p[31:0]));
    p = longint'(a16) * longint'(b16);
    chk({"R3 w16 ", tag}, 64'(s16u), 64'(p[31:0]));
  endtask

  task automatic t_random16();
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk);
      a16 = 16'($urandom);
      b16 = 16'($urandom);
      @(negedge clk);
      check16("random");
    end
  endtask

  task automatic t_corner16();
    logic [15:0] ca [8] = '{16'h8000, 16'h8000, 16'hFFFF, 16'h7FFF,
                            16'h0000, 16'hAAAA, 16'h8000, 16'h0001};
    logic [15:0] cb [8] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h7FFF,
                            16'hFFFF, 16'h5555, 16'hFFFF, 16'h8000};
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      a16 = ca[k];
      b16 = cb[k];
      @(negedge clk);
      check16("corner");
      // R8: signed last row holds only the carry of row 7 (opB[15]) at bit 14.
      chk("R8 w16 last row", 64'(r16s[8]), 64'(32'(b16[15]) << 14));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    a4 = '0; b4 = '0; a6 = '0; b6 = '0; a16 = '0; b16 = '0;
    t_shape();
    t_zero();
    t_exhaustive();
    t_random16();
    t_corner16();
    finish_run();
  end

endmodule